// File: doc/BRIEF.md
# Pipeline Event Counter Bank

This block watches a five-stage in-order pipeline and keeps a bank of saturating event counters for performance analysis. Every instruction that reaches the execute stage is sorted by its 4-bit opcode into one of seven fixed classes: arithmetic, logical, shift, memory, load-immediate, control and halt. Each class has its own counter. Further counters track three other events. One counts cycles in which any stage did useful work. One counts decode cycles lost to read-after-write hazards. One counts control-hazard bubbles, and it adds two for every jump or branch that decode recognises, because a redirect costs two fetch slots.

Software reads the counters through an indexed port. It presents a 4-bit select and receives the registered value one cycle later. Two of the select codes return derived totals. One is the saturated sum of the seven class counters. The other is the saturated sum of the two stall counters. Software divides the cycle count by the instruction total to get the CPI figure. A synchronous clear zeroes the whole bank. Every counter stops at its all-ones value and does not wrap.

Top module: `pipe_perf_counters`

## Requirements
- R1: With `ex_valid_i` high, opcodes 0, 1, 2 and 3 (add, subtract, multiply, increment) each add one to the arithmetic counter, which is read with select 1.
- R2: With `ex_valid_i` high, opcodes 4, 5, 6 and 7 (and, or, xor, not) each add one to the logical counter, which is read with select 2.
- R3: With `ex_valid_i` high, opcodes 8 and 9 (shift left, shift right) add one to the shift counter (select 3). Opcodes 11 and 12 (load, store) add one to the memory counter (select 4).
- R4: With `ex_valid_i` high, opcode 10 (load immediate) counts at select 5, opcodes 13 and 14 (jump, branch-if-zero) count at select 6, and opcode 15 (halt) counts at select 7. No class counter changes in a cycle with `ex_valid_i` low, and an opcode changes no counter outside its own class.
- R5: The data-stall counter (select 8) adds one in every cycle that `dec_raw_stall_i` is high.
- R6: The control-stall counter (select 9) adds two in every cycle that `dec_redirect_i` is high.
- R7: The active-cycle counter (select 0) adds one in every cycle that `pipe_busy_i` is high and holds while it is low.
- R8: Select 10 returns the sum of the seven class counters and select 11 returns the sum of the two stall counters. Each sum is clipped to 0xFFFF.
- R9: Every counter saturates at 0xFFFF and never wraps. This includes a step of two that starts at 0xFFFE or 0xFFFF.
- R10: When `clr_i` is high at a clock edge, every counter becomes zero at that edge. The clear overrides any event strobe in the same cycle.
- R11: `rd_data_o` shows, one cycle after the edge that samples `rd_sel_i`, the value the selected counter held before that edge. Events in the sampling cycle are therefore not included. Selects 12 to 15 return zero.
- R12: After reset every counter and `rd_data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous clear of all counters |
| ex_valid_i | input | 1 | An instruction occupies execute this cycle |
| ex_op_i | input | 4 | Opcode of the instruction in execute |
| dec_raw_stall_i | input | 1 | Decode is held this cycle by a read-after-write hazard |
| dec_redirect_i | input | 1 | Decode recognised a jump or branch this cycle |
| pipe_busy_i | input | 1 | At least one pipeline stage did work this cycle |
| rd_sel_i | input | 4 | Counter select for the read port |
| rd_data_o | output | 16 | Registered value of the selected counter |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a clear arrives together with every event strobe. The bench raises `clr_i`, `ex_valid_i`, `dec_raw_stall_i`, `dec_redirect_i` and `pipe_busy_i` in one cycle, then reads every select; each must return zero, so the clear has won. In the second, a read is sampled in the same cycle that a stall strobe counts. The bench presents select 8 while `dec_raw_stall_i` is high. It expects the pre-event value back first, and the incremented value on a second read.

// File: rtl/perf_pkg.sv
package perf_pkg;

    localparam int OP_W  = 4;
    localparam int NCLS  = 7;

    // Counter bank layout: class counters first, then the three event counters.
    localparam int IDX_ARITH = 0;
    localparam int IDX_LOGIC = 1;
    localparam int IDX_SHIFT = 2;
    localparam int IDX_MEM   = 3;
    localparam int IDX_LDI   = 4;
    localparam int IDX_CTRL  = 5;
    localparam int IDX_HALT  = 6;
    localparam int IDX_CYC   = 7;
    localparam int IDX_DST   = 8;
    localparam int IDX_CST   = 9;
    localparam int NCTR      = 10;

    typedef enum logic [OP_W-1:0] {
        OPC_ADD   = 4'd0,
        OPC_SUB   = 4'd1,
        OPC_MUL   = 4'd2,
        OPC_INC   = 4'd3,
        OPC_AND   = 4'd4,
        OPC_OR    = 4'd5,
        OPC_XOR   = 4'd6,
        OPC_NOT   = 4'd7,
        OPC_SHL   = 4'd8,
        OPC_SHR   = 4'd9,
        OPC_LDI   = 4'd10,
        OPC_LOAD  = 4'd11,
        OPC_STORE = 4'd12,
        OPC_JUMP  = 4'd13,
        OPC_BRZ   = 4'd14,
        OPC_HALT  = 4'd15
    } opc_e;

    typedef enum logic [3:0] {
        RS_CYCLES    = 4'd0,
        RS_ARITH     = 4'd1,
        RS_LOGIC     = 4'd2,
        RS_SHIFT     = 4'd3,
        RS_MEM       = 4'd4,
        RS_LDI       = 4'd5,
        RS_CTRL      = 4'd6,
        RS_HALT      = 4'd7,
        RS_DSTALL    = 4'd8,
        RS_CSTALL    = 4'd9,
        RS_TOT_INSTR = 4'd10,
        RS_TOT_STALL = 4'd11
    } rd_sel_e;

    // One-hot class vector for an opcode (R1..R4).
    function automatic logic [NCLS-1:0] class_of(input opc_e op);
        logic [NCLS-1:0] v;
        v = '0;
        unique case (op)
            OPC_ADD, OPC_SUB, OPC_MUL, OPC_INC: v[IDX_ARITH] = 1'b1;
            OPC_AND, OPC_OR, OPC_XOR, OPC_NOT:  v[IDX_LOGIC] = 1'b1;
            OPC_SHL, OPC_SHR:                   v[IDX_SHIFT] = 1'b1;
            OPC_LOAD, OPC_STORE:                v[IDX_MEM]   = 1'b1;
            OPC_LDI:                            v[IDX_LDI]   = 1'b1;
            OPC_JUMP, OPC_BRZ:                  v[IDX_CTRL]  = 1'b1;
            OPC_HALT:                           v[IDX_HALT]  = 1'b1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/perf_classify.sv
module perf_classify
    import perf_pkg::*;
(
    input  logic            valid_i,
    input  logic [OP_W-1:0] op_i,
    output logic [NCLS-1:0] hit_o
);

    always_comb begin
        if (valid_i) begin
            hit_o = class_of(opc_e'(op_i));
        end else begin
            hit_o = '0;
        end
    end

endmodule

// File: rtl/perf_sat_ctr.sv
module perf_sat_ctr #(
    parameter int W      = 16,
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [STEP_W-1:0] inc_i,
    output logic [W-1:0]      q_o
);

    localparam int SW = W + 1;

    logic [SW-1:0] sum;

    always_comb begin
        sum = {1'b0, q_o} + SW'(inc_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (clr_i) begin
            q_o <= '0;
        end else if (sum[W]) begin
            q_o <= '1;
        end else begin
            q_o <= sum[W-1:0];
        end
    end

endmodule

// File: rtl/perf_read_port.sv
module perf_read_port
    import perf_pkg::*;
#(
    parameter int W     = 16,
    parameter int SEL_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCTR-1:0][W-1:0]   cnt_i,
    input  logic [SEL_W-1:0]         sel_i,
    output logic [W-1:0]             data_o
);

    localparam int TW = W + $clog2(NCLS + 1);

    logic [TW-1:0] sum_instr;
    logic [W:0]    sum_stall;
    logic [W-1:0]  tot_instr;
    logic [W-1:0]  tot_stall;
    logic [W-1:0]  mux;

    always_comb begin
        sum_instr = '0;
        for (int k = 0; k < NCLS; k++) begin
            sum_instr = sum_instr + TW'(cnt_i[k]);
        end
        tot_instr = (|sum_instr[TW-1:W]) ? '1 : sum_instr[W-1:0];
        sum_stall = {1'b0, cnt_i[IDX_DST]} + {1'b0, cnt_i[IDX_CST]};
        tot_stall = sum_stall[W] ? '1 : sum_stall[W-1:0];
    end

    always_comb begin
        case (rd_sel_e'(sel_i))
            RS_CYCLES:    mux = cnt_i[IDX_CYC];
            RS_ARITH:     mux = cnt_i[IDX_ARITH];
            RS_LOGIC:     mux = cnt_i[IDX_LOGIC];
            RS_SHIFT:     mux = cnt_i[IDX_SHIFT];
            RS_MEM:       mux = cnt_i[IDX_MEM];
            RS_LDI:       mux = cnt_i[IDX_LDI];
            RS_CTRL:      mux = cnt_i[IDX_CTRL];
            RS_HALT:      mux = cnt_i[IDX_HALT];
            RS_DSTALL:    mux = cnt_i[IDX_DST];
            RS_CSTALL:    mux = cnt_i[IDX_CST];
            RS_TOT_INSTR: mux = tot_instr;
            RS_TOT_STALL: mux = tot_stall;
            default:      mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
        end else begin
            data_o <= mux;
        end
    end

endmodule

// File: rtl/pipe_perf_counters.sv
module pipe_perf_counters
    import perf_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ex_valid_i,
    input  logic [OP_W-1:0]  ex_op_i,
    input  logic             dec_raw_stall_i,
    input  logic             dec_redirect_i,
    input  logic             pipe_busy_i,
    input  logic [SEL_W-1:0] rd_sel_i,
    output logic [CNT_W-1:0] rd_data_o
);

    localparam int STEP_W = 2;

    logic [NCLS-1:0]            cls_hit;
    logic [NCTR-1:0][CNT_W-1:0] cnt_q;

    perf_classify u_classify (
        .valid_i (ex_valid_i),
        .op_i    (ex_op_i),
        .hit_o   (cls_hit)
    );

    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        perf_sat_ctr #(.W(CNT_W), .STEP_W(STEP_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_i),
            .inc_i ({1'b0, cls_hit[g]}),
            .q_o   (cnt_q[g])
        );
    end

    perf_sat_ctr #(.W(CNT_W), .STEP_W(STEP_W)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .inc_i ({1'b0, pipe_busy_i}),
        .q_o   (cnt_q[IDX_CYC])
    );

    perf_sat_ctr #(.W(CNT_W), .STEP_W(STEP_W)) u_dstall (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .inc_i ({1'b0, dec_raw_stall_i}),
        .q_o   (cnt_q[IDX_DST])
    );

    // A redirect costs two fetch slots, so it steps by two.
    perf_sat_ctr #(.W(CNT_W), .STEP_W(STEP_W)) u_cstall (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .inc_i ({dec_redirect_i, 1'b0}),
        .q_o   (cnt_q[IDX_CST])
    );

    perf_read_port #(.W(CNT_W), .SEL_W(SEL_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_i  (cnt_q),
        .sel_i  (rd_sel_i),
        .data_o (rd_data_o)
    );

endmodule

// File: rtl/pipe_perf_counters_chk.sv
module pipe_perf_counters_chk
    import perf_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       clr_i,
    input logic                       ex_valid_i,
    input logic                       dec_raw_stall_i,
    input logic                       dec_redirect_i,
    input logic                       pipe_busy_i,
    input logic [SEL_W-1:0]           rd_sel_i,
    input logic [CNT_W-1:0]           rd_data_o,
    input logic [NCTR-1:0][CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] MAXV = '1;

    p_cycle_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_busy_i && !clr_i && cnt_q[IDX_CYC] != MAXV)
        |=> cnt_q[IDX_CYC] == $past(cnt_q[IDX_CYC]) + 1'b1);

    p_cycle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_busy_i && !clr_i) |=> $stable(cnt_q[IDX_CYC]));

    p_dstall_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_raw_stall_i && !clr_i && cnt_q[IDX_DST] != MAXV)
        |=> cnt_q[IDX_DST] == $past(cnt_q[IDX_DST]) + 1'b1);

    p_cstall_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_redirect_i && !clr_i)
        |=> cnt_q[IDX_CST] == (($past(cnt_q[IDX_CST]) >= MAXV - 1'b1)
                               ? MAXV : $past(cnt_q[IDX_CST]) + 2'd2));

    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[IDX_CYC] == MAXV && !clr_i) |=> cnt_q[IDX_CYC] == MAXV);

    p_idle_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_valid_i && !clr_i) |=> $stable(cnt_q[IDX_HALT:IDX_ARITH]));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0);

    p_read_cyc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel_i == SEL_W'(0)) |=> rd_data_o == $past(cnt_q[IDX_CYC]));

endmodule

bind pipe_perf_counters pipe_perf_counters_chk #(
    .CNT_W(CNT_W),
    .SEL_W(SEL_W)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .clr_i           (clr_i),
    .ex_valid_i      (ex_valid_i),
    .dec_raw_stall_i (dec_raw_stall_i),
    .dec_redirect_i  (dec_redirect_i),
    .pipe_busy_i     (pipe_busy_i),
    .rd_sel_i        (rd_sel_i),
    .rd_data_o       (rd_data_o),
    .cnt_q           (cnt_q)
);

// File: tb/pipe_perf_counters_tb.sv
`timescale 1ns/1ps
module pipe_perf_counters_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        ex_valid = 1'b0;
    logic [3:0]  ex_op = 4'd0;
    logic        stall = 1'b0;
    logic        redir = 1'b0;
    logic        busy = 1'b0;
    logic [3:0]  sel = 4'd0;
    logic [15:0] rd;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    pipe_perf_counters dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .clr_i           (clr),
        .ex_valid_i      (ex_valid),
        .ex_op_i         (ex_op),
        .dec_raw_stall_i (stall),
        .dec_redirect_i  (redir),
        .pipe_busy_i     (busy),
        .rd_sel_i        (sel),
        .rd_data_o       (rd)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic        v;
        logic        s;
        logic        c;
        logic        b;
        logic [7:0]  reps;
        logic [3:0]  rsel;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 8'd5,  4'd1,  16'd5},  // R1 add
        '{4'd3,  1'b1, 1'b0, 1'b0, 1'b0, 8'd3,  4'd1,  16'd3},  // R1 increment
        '{4'd7,  1'b1, 1'b0, 1'b0, 1'b0, 8'd4,  4'd2,  16'd4},  // R2 not
        '{4'd5,  1'b1, 1'b0, 1'b0, 1'b0, 8'd2,  4'd2,  16'd2},  // R2 or
        '{4'd9,  1'b1, 1'b0, 1'b0, 1'b0, 8'd6,  4'd3,  16'd6},  // R3 shift right
        '{4'd12, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2,  4'd4,  16'd2},  // R3 store
        '{4'd10, 1'b1, 1'b0, 1'b0, 1'b0, 8'd7,  4'd5,  16'd7},  // R4 load immediate
        '{4'd14, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3,  4'd6,  16'd3},  // R4 branch
        '{4'd15, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1,  4'd7,  16'd1},  // R4 halt
        '{4'd2,  1'b0, 1'b0, 1'b0, 1'b0, 8'd5,  4'd1,  16'd0},  // R4 valid low
        '{4'd13, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2,  4'd4,  16'd0},  // R4 other class
        '{4'd0,  1'b0, 1'b1, 1'b0, 1'b0, 8'd9,  4'd8,  16'd9},  // R5
        '{4'd0,  1'b0, 1'b0, 1'b1, 1'b0, 8'd4,  4'd9,  16'd8},  // R6
        '{4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 8'd10, 4'd0,  16'd10}, // R7 busy
        '{4'd6,  1'b1, 1'b0, 1'b0, 1'b0, 8'd5,  4'd0,  16'd0},  // R7 idle
        '{4'd6,  1'b1, 1'b0, 1'b0, 1'b0, 8'd5,  4'd10, 16'd5},  // R8 instr total
        '{4'd0,  1'b0, 1'b1, 1'b1, 1'b0, 8'd3,  4'd11, 16'd9},  // R8 stall total
        '{4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 8'd3,  4'd15, 16'd0},  // R11 unused select
        '{4'd8,  1'b1, 1'b0, 1'b0, 1'b0, 8'd4,  4'd3,  16'd4},  // R3 shift left
        '{4'd11, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3,  4'd10, 16'd3}   // R8 load in total
    };

    function automatic string req_of(int i);
        case (i)
            0, 1:                return "R1";
            2, 3:                return "R2";
            4, 5, 18:            return "R3";
            6, 7, 8, 9, 10:      return "R4";
            11:                  return "R5";
            12:                  return "R6";
            13, 14:              return "R7";
            15, 16, 19:          return "R8";
            default:             return "R11";
        endcase
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic idle();
        ex_valid = 1'b0; stall = 1'b0; redir = 1'b0; busy = 1'b0; clr = 1'b0;
    endtask

    task automatic pulse_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic drive(logic [3:0] op, logic v, logic s, logic c, logic b, int reps);
        ex_op = op; ex_valid = v; stall = s; redir = c; busy = b;
        repeat (reps) @(negedge clk);
        idle();
    endtask

    task automatic read_ctr(logic [3:0] s, output logic [15:0] val);
        sel = s;
        @(negedge clk);
        val = rd;
    endtask

    initial begin
        logic [15:0] v;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        check("R12", rd, 16'd0);
        for (int k = 0; k < 12; k++) begin
            read_ctr(4'(k), v);
            check("R12", v, 16'd0);
        end

        // Table walk
        for (int i = 0; i < NV; i++) begin
            pulse_clear();
            drive(VEC[i].op, VEC[i].v, VEC[i].s, VEC[i].c, VEC[i].b, int'(VEC[i].reps));
            read_ctr(VEC[i].rsel, v);
            check(req_of(i), v, VEC[i].exp);
        end

        // R11: read sampled in the same cycle as a stall event
        pulse_clear();
        drive(4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3);
        sel = 4'd8; stall = 1'b1;
        @(negedge clk);
        stall = 1'b0;
        check("R11", rd, 16'd3);
        read_ctr(4'd8, v);
        check("R11", v, 16'd4);

        // R10: clear coinciding with every event strobe
        drive(4'd1, 1'b1, 1'b1, 1'b1, 1'b1, 4);
        clr = 1'b1; ex_valid = 1'b1; ex_op = 4'd4; stall = 1'b1; redir = 1'b1; busy = 1'b1;
        @(negedge clk);
        idle();
        for (int k = 0; k < 12; k++) begin
            read_ctr(4'(k), v);
            check("R10", v, 16'd0);
        end

        // R9 / R8: long run into saturation
        for (int i = 0; i < 70000; i++) begin
            ex_valid = 1'b1; busy = 1'b1; redir = 1'b1;
            ex_op = (i < 35000) ? 4'd0 : 4'd4;
            stall = (i < 40000);
            @(negedge clk);
        end
        idle();
        read_ctr(4'd0, v);  check("R9", v, 16'hFFFF);
        read_ctr(4'd1, v);  check("R1", v, 16'd35000);
        read_ctr(4'd2, v);  check("R2", v, 16'd35000);
        read_ctr(4'd10, v); check("R8", v, 16'hFFFF);
        read_ctr(4'd8, v);  check("R5", v, 16'd40000);
        read_ctr(4'd9, v);  check("R9", v, 16'hFFFF);
        read_ctr(4'd11, v); check("R8", v, 16'hFFFF);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule